// File: doc/BRIEF.md
# Memory Access Watchpoint Interrupt

This block observes three memory access ports: one for on-chip RAM, one for the instruction tightly coupled memory and one for the data tightly coupled memory. Each port carries a valid strobe, a write flag and a byte address. Every port has its own programmable watch address and its own direction selector. When a valid access in the selected direction lands on the watched 8-byte word, that port's sticky status flag is set.

Two enable masks control each flag. The status-enable mask decides whether a hit may latch at all. The signal-enable mask decides whether a latched flag contributes to the single registered interrupt output. Software programs the block through a small register port. It has a write strobe and a register-select input. Read data is registered and reflects the register selected in the previous cycle.

Top module: `mem_watch_irq`

## Requirements
- R1: After synchronous reset, all watch registers, the status flags, both enable masks, `reg_rdata` and `irq` are zero.
- R2: A hit compares byte-address bits [18:3] with the 16-bit field held in bits [16:1] of the unit's watch register. Address bits [2:0] and bits above 18 are ignored, and so are watch-register bits above 16 when it is written.
- R3: Bit 0 of a watch register selects the direction. A value of 0 matches reads only (`acc_write`=0) and a value of 1 matches writes only (`acc_write`=1).
- R4: An access with its valid strobe low never sets a flag.
- R5: A hit sets its flag at the clock edge on which it is presented, but only when that unit's status-enable bit is 1. With the bit at 0, the flag stays unchanged.
- R6: Flags are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: When a latching hit and a clear of the same flag fall on the same edge, the flag stays set.
- R8: `irq` is a register loaded with the OR over all units of (flag AND signal-enable bit). It therefore follows the flags one cycle later.
- R9: The units are independent. Status, status-enable and signal-enable bit 0 belong to on-chip RAM, bit 1 to the instruction memory and bit 2 to the data memory. Access port i uses `acc_addr[32*i+31:32*i]`.
- R10: The register select values are: 0, 1 and 2 for the watch registers of units 0, 1 and 2; 4 for status; 5 for status-enable; 6 for signal-enable. Any other value reads as zero. `reg_rdata` is loaded at each clock edge with the register selected at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| acc_valid | input | 3 | Per-port access valid |
| acc_write | input | 3 | Per-port direction, 1 = write |
| acc_addr | input | 96 | Per-port byte address, 32 bits per port |
| irq | output | 1 | Registered interrupt |

## Verification
The hardest case to reach from the ports is a watch hit that coincides with a write-1-to-clear of the same flag. The bench reaches it by driving the access strobe and the status register write in the same half-cycle, so both reach the design on one edge. The one-cycle lag of `irq` behind the flag is checked on consecutive cycles after a hit. A further check confirms that clearing the signal-enable mask drops `irq` while the flag stays set. Address bits outside [18:3] are exercised with patterns that set only the high and low bits around a match. A watch word is also written with junk above bit 16.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int NUM_UNITS = 3;
  localparam int REG_AW    = 3;
  localparam int DATA_W    = 32;
  localparam int FIELD_W   = 16;
  localparam int WORD_LSB  = 3;

  localparam logic [REG_AW-1:0] OFS_STATUS  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_STAT_EN = 3'd5;
  localparam logic [REG_AW-1:0] OFS_SIG_EN  = 3'd6;
endpackage

// File: rtl/wm_watch_unit.sv
module wm_watch_unit #(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 16,
  parameter int LSB     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [FIELD_W-1:0] watch_field,
  input  logic               watch_dir,
  input  logic               stat_en,
  input  logic               clr,
  output logic               flag
);
  localparam int MSB = LSB + FIELD_W - 1;

  logic hit_raw;
  assign hit_raw = acc_valid && (acc_write == watch_dir) &&
                   (acc_addr[MSB:LSB] == watch_field);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag & ~clr) | (hit_raw & stat_en);
  end

  // R6: a set flag survives unless cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag) else $error("a_r6_sticky");
  // R5: no latching while status enable is low
  a_r5_gate: assert property (@(posedge clk) disable iff (rst)
    (!flag && !stat_en) |=> !flag) else $error("a_r5_gate");
  // R7: an enabled hit wins over a simultaneous clear
  a_r7_hit_wins: assert property (@(posedge clk) disable iff (rst)
    (hit_raw && stat_en) |=> flag) else $error("a_r7_hit_wins");
  // R4: no strobe, no new flag
  a_r4_valid: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !flag) |=> !flag) else $error("a_r4_valid");
endmodule

// File: rtl/wm_regfile.sv
module wm_regfile
  import wm_pkg::*;
#(
  parameter int N       = NUM_UNITS,
  parameter int FW      = FIELD_W,
  parameter int DW      = DATA_W,
  parameter int AW      = REG_AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [N-1:0]         flags,
  output logic [N-1:0][FW-1:0] watch_field,
  output logic [N-1:0]         watch_dir,
  output logic [N-1:0]         stat_en,
  output logic [N-1:0]         sig_en,
  output logic [N-1:0]         clr
);
  logic [DW-1:0] rd_next;

  assign clr = (reg_wr_en && reg_addr == OFS_STATUS) ? reg_wdata[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      watch_field <= '0;
      watch_dir   <= '0;
      stat_en     <= '0;
      sig_en      <= '0;
    end else if (reg_wr_en) begin
      for (int i = 0; i < N; i++) begin
        if (reg_addr == AW'(i)) begin
          watch_field[i] <= reg_wdata[FW:1];
          watch_dir[i]   <= reg_wdata[0];
        end
      end
      if (reg_addr == OFS_STAT_EN) stat_en <= reg_wdata[N-1:0];
      if (reg_addr == OFS_SIG_EN)  sig_en  <= reg_wdata[N-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < N; i++) begin
      if (reg_addr == AW'(i)) rd_next = DW'({watch_field[i], watch_dir[i]});
    end
    if (reg_addr == OFS_STATUS)  rd_next = DW'(flags);
    if (reg_addr == OFS_STAT_EN) rd_next = DW'(stat_en);
    if (reg_addr == OFS_SIG_EN)  rd_next = DW'(sig_en);
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  // R10: signal enable only moves on a write to its offset
  a_r10_sig_hold: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_addr == OFS_SIG_EN) |=> $stable(sig_en))
    else $error("a_r10_sig_hold");
endmodule

// File: rtl/mem_watch_irq.sv
module mem_watch_irq
  import wm_pkg::*;
#(
  parameter int N_UNITS = NUM_UNITS,
  parameter int ADDR_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr_en,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic [N_UNITS-1:0]          acc_valid,
  input  logic [N_UNITS-1:0]          acc_write,
  input  logic [N_UNITS*ADDR_W-1:0]   acc_addr,
  output logic                        irq
);
  logic [N_UNITS-1:0][FIELD_W-1:0] watch_field;
  logic [N_UNITS-1:0]              watch_dir;
  logic [N_UNITS-1:0]              stat_en;
  logic [N_UNITS-1:0]              sig_en;
  logic [N_UNITS-1:0]              clr;
  logic [N_UNITS-1:0]              flags;

  wm_regfile #(.N(N_UNITS)) regs_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flags(flags), .watch_field(watch_field), .watch_dir(watch_dir),
    .stat_en(stat_en), .sig_en(sig_en), .clr(clr)
  );

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    wm_watch_unit #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .LSB(WORD_LSB)) unit_i (
      .clk(clk), .rst(rst),
      .acc_valid(acc_valid[g]), .acc_write(acc_write[g]),
      .acc_addr(acc_addr[g*ADDR_W +: ADDR_W]),
      .watch_field(watch_field[g]), .watch_dir(watch_dir[g]),
      .stat_en(stat_en[g]), .clr(clr[g]), .flag(flags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & sig_en);
  end

  // R8: interrupt is the registered masked OR of the flags
  a_r8_irq: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(|(flags & sig_en))))
    else $error("a_r8_irq");
endmodule

// File: tb/mem_watch_irq_tb_top.sv
`timescale 1ns/1ps
module mem_watch_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  acc_valid = '0;
  logic [2:0]  acc_write = '0;
  logic [95:0] acc_addr = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mem_watch_irq dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .irq(irq)
  );

  // {unit[1:0], write, addr[31:0], expected status[2:0]}
  localparam logic [37:0] VEC [10] = '{
    {2'd0, 1'b0, 32'h0000_91A0, 3'b001},  // R2 R3 exact read hit
    {2'd0, 1'b1, 32'h0000_91A0, 3'b000},  // R3 wrong direction
    {2'd0, 1'b0, 32'hFFF8_91A7, 3'b001},  // R2 outer bits ignored
    {2'd0, 1'b0, 32'h0000_91A8, 3'b000},  // R2 next word misses
    {2'd1, 1'b1, 32'h0005_5E68, 3'b010},  // R3 R9 write hit
    {2'd1, 1'b0, 32'h0005_5E68, 3'b000},  // R3 read on write watch
    {2'd2, 1'b0, 32'h0000_0008, 3'b100},  // R9 data unit
    {2'd2, 1'b0, 32'h0000_0000, 3'b000},  // R2 word 0 misses
    {2'd2, 1'b0, 32'h0004_0008, 3'b000},  // R2 bit 18 compared
    {2'd1, 1'b1, 32'h000D_5E6F, 3'b010}   // R2 bit 19 ignored
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic access(input int u, input logic w, input logic [31:0] a, input logic v);
    @(negedge clk);
    acc_valid = '0; acc_write = '0; acc_addr = '0;
    acc_valid[u] = v; acc_write[u] = w; acc_addr[u*32 +: 32] = a;
    @(negedge clk);
    acc_valid = '0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(3'd0, d); check("R1 watch0 reset", d, 32'h0);
    rd(3'd4, d); check("R1 status reset", d, 32'h0);
    rd(3'd5, d); check("R1 stat_en reset", d, 32'h0);
    rd(3'd6, d); check("R1 sig_en reset", d, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);

    wr(3'd0, 32'hFFFE_2468);
    wr(3'd1, 32'h0001_579B);
    wr(3'd2, 32'h0000_0002);
    rd(3'd0, d); check("R2 R10 watch0 readback", d, 32'h0000_2468);
    rd(3'd1, d); check("R10 watch1 readback", d, 32'h0001_579B);
    rd(3'd3, d); check("R10 unused offset", d, 32'h0);
    wr(3'd5, 32'h7);
    rd(3'd5, d); check("R10 stat_en readback", d, 32'h7);

    for (int i = 0; i < 10; i++) begin
      access(int'(VEC[i][37:36]), VEC[i][35], VEC[i][34:3], 1'b1);
      rd(3'd4, d);
      check($sformatf("R2 R3 R9 vector %0d", i), d, {29'b0, VEC[i][2:0]});
      wr(3'd4, 32'h7);
    end

    // R4: invalid strobe
    access(0, 1'b0, 32'h0000_91A0, 1'b0);
    rd(3'd4, d); check("R4 invalid strobe", d, 32'h0);

    // R9: all three at once
    @(negedge clk);
    acc_valid = 3'b111; acc_write = 3'b010;
    acc_addr = {32'h0000_0008, 32'h0005_5E68, 32'h0000_91A0};
    @(negedge clk);
    acc_valid = '0;
    rd(3'd4, d); check("R9 all units", d, 32'h7);
    wr(3'd4, 32'h7);

    // R5: status enable masks latching
    wr(3'd5, 32'h6);
    access(0, 1'b0, 32'h0000_91A0, 1'b1);
    rd(3'd4, d); check("R5 disabled no latch", d, 32'h0);
    wr(3'd5, 32'h7);

    // R6: write-0 and other bits do not clear
    access(0, 1'b0, 32'h0000_91A0, 1'b1);
    wr(3'd4, 32'h0);
    rd(3'd4, d); check("R6 write 0 keeps", d, 32'h1);
    wr(3'd4, 32'h6);
    rd(3'd4, d); check("R6 other bits keep", d, 32'h1);
    wr(3'd4, 32'h1);
    rd(3'd4, d); check("R6 write 1 clears", d, 32'h0);

    // R7: hit and clear on the same edge
    access(0, 1'b0, 32'h0000_91A0, 1'b1);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1;
    acc_valid = 3'b001; acc_write = '0; acc_addr = {64'h0, 32'h0000_91A0};
    @(negedge clk);
    reg_wr_en = 1'b0; acc_valid = '0;
    rd(3'd4, d); check("R7 hit beats clear", d, 32'h1);
    wr(3'd4, 32'h7);

    // R8: interrupt timing and masking
    wr(3'd6, 32'h2);
    access(0, 1'b0, 32'h0000_91A0, 1'b1);
    @(negedge clk);
    check("R8 masked flag no irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    acc_valid = 3'b010; acc_write = 3'b010; acc_addr = {32'h0, 32'h0005_5E68, 32'h0};
    @(negedge clk);
    acc_valid = '0;
    check("R8 irq lags flag", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    wr(3'd6, 32'h0);
    @(negedge clk);
    check("R8 irq drops with mask", {31'b0, irq}, 32'h0);
    rd(3'd4, d); check("R8 flags kept", d, 32'h3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule